// File: doc/BRIEF.md
# Outbound PCIe Address Translator

This block sits on an endpoint between a local write port and the PCIe request port. Local writes that land in a fixed 256 MB outbound aperture are turned into PCIe memory writes. Writes that land anywhere else are dropped and reported. The aperture is cut into equal windows whose size software selects. Each window carries its own translation base, so a write leaves the endpoint at `base + offset-within-window`.

When translation is switched off, the block still forwards aperture writes. The address keeps its 28-bit aperture offset and its top nibble is cleared. Either mode lets local software raise a message-signalled interrupt with a single data write:

- With translation on, software points a window at the interrupt target.
- With translation off, software writes at aperture base plus the target offset.

A small write-only register port holds the enable bit, the window size code and one base register per window. Data passes through unchanged. One output register decouples the two valid/ready channels.

Top module: `pcie_obx_top`

## Requirements
- R1: After reset, `pcie_valid` and `range_err` are 0 and `wr_ready` is 1. Translation is off, the size code is 3 (8 MB windows) and every window base is cleared and not valid.
- R2: With translation off, the block forwards a write whose address top nibble equals 0x2 as one PCIe write. Its address is the local address with bits 31:28 cleared, and its data is the local data unchanged.
- R3: Register port layout:
  - `cfg_addr` 0 is control: bit 0 enables translation and bits 7:4 hold size code c, giving windows of 2^(20+c) bytes.
  - `cfg_addr` 32+i is the base for window i; bit 0 of that written word marks window i valid.
  - With translation on, the output address is the selected window's base with its in-window bits replaced by the local offset's in-window bits (example: base 0x6000_0000, local 0x2000_0010 → 0x6000_0010).
- R4: The window index is the 28-bit aperture offset shifted right by 20+c (8 MB windows: local 0x2080_0010 selects window 1).
- R5: Base bits below the window size have no effect on the output address.
- R6: With translation on, an aperture write is not forwarded, and `range_err` is high for exactly one cycle, in either of two cases:
  - the window index is not below NUM_WIN (32), or
  - the indexed window is not valid.
- R7: A write whose address top nibble is not 0x2 is never forwarded, and `range_err` pulses for one cycle, whether translation is on or off.
- R8: Each accepted, forwarded write gives exactly one cycle of `pcie_valid` when `pcie_ready` is high, and that cycle is the one after acceptance.
- R9: While `pcie_valid` is high and `pcie_ready` is low, `wr_ready` is 0, and the PCIe address and data stay stable.
- R10: Size codes above 8 behave as code 8, which gives one 256 MB window that uses window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register index (0 control, 32+i window base) |
| cfg_wdata | input | 32 | Register write value |
| wr_valid | input | 1 | Local write request valid |
| wr_ready | output | 1 | Local write accepted this cycle when high with valid |
| wr_addr | input | 32 | Local write address |
| wr_data | input | 32 | Local write data |
| pcie_valid | output | 1 | Outbound PCIe write valid |
| pcie_ready | input | 1 | PCIe request port can take the write |
| pcie_addr | output | 32 | Translated PCIe address |
| pcie_data | output | 32 | Write data, unchanged |
| range_err | output | 1 | One-cycle pulse for a dropped write |

## Verification
The properties assume that the register port is not written in the cycle a local write is accepted. They also assume that the address and data of a pending local write hold until `wr_ready` takes them. The mode and window configuration then seen by each accepted write is the one software last wrote. The directed bench meets these assumptions by writing configuration only while the write channel is idle. It also keeps each request unchanged until the cycle in which it is accepted, including during the stall scenario.

// File: rtl/pcie_obx_pkg.sv
package pcie_obx_pkg;

   // log2 of the window size for a size code, clamped to the aperture
   function automatic logic [5:0] win_lg2(input logic [3:0] code,
                                          input int unsigned min_lg,
                                          input int unsigned off_w);
      int unsigned v;
      v = min_lg + int'(code);
      if (v > off_w) v = off_w;
      return 6'(v);
   endfunction

endpackage

// File: rtl/pcie_obx_cfg.sv
module pcie_obx_cfg #(
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned NUM_WIN = 32,
   parameter int unsigned RST_SZ  = 3,
   localparam int unsigned IDX_W  = $clog2(NUM_WIN),
   localparam int unsigned CFG_AW = IDX_W + 1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic [CFG_AW-1:0]               cfg_addr,
   input  logic [ADDR_W-1:0]               cfg_wdata,
   output logic                            xl_en,
   output logic [3:0]                      sz_code,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]  win_base,
   output logic [NUM_WIN-1:0]              win_vld
);

   wire unused_ctl_bits = ^{cfg_wdata[ADDR_W-1:8], cfg_wdata[3:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xl_en   <= 1'b0;
         sz_code <= 4'(RST_SZ);
      end else if (cfg_we && cfg_addr == '0) begin
         xl_en   <= cfg_wdata[0];
         sz_code <= cfg_wdata[7:4];
      end
   end

   for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            win_base[i] <= '0;
            win_vld[i]  <= 1'b0;
         end else if (cfg_we && cfg_addr == {1'b1, IDX_W'(i)}) begin
            win_base[i] <= cfg_wdata;
            win_vld[i]  <= cfg_wdata[0];
         end
      end
   end

endmodule

// File: rtl/pcie_obx_map.sv
module pcie_obx_map
   import pcie_obx_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned OFF_W     = 28,
   parameter int unsigned MIN_LG    = 20,
   parameter int unsigned NUM_WIN   = 32,
   parameter logic [31:0] APER_BASE = 32'h2000_0000,
   parameter bit          HAS_XLATE = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_WIN),
   localparam int unsigned TAG_W    = ADDR_W - OFF_W
) (
   input  logic [ADDR_W-1:0]               addr,
   input  logic                            xl_en,
   input  logic [3:0]                      sz_code,
   input  logic [NUM_WIN-1:0][ADDR_W-1:0]  win_base,
   input  logic [NUM_WIN-1:0]              win_vld,
   output logic                            ok,
   output logic [ADDR_W-1:0]               map_addr
);

   logic              in_ap;
   logic [OFF_W-1:0]  off;
   logic [ADDR_W-1:0] byp_addr;

   assign off      = addr[OFF_W-1:0];
   assign in_ap    = addr[ADDR_W-1:OFF_W] == APER_BASE[ADDR_W-1:OFF_W];
   assign byp_addr = {{TAG_W{1'b0}}, off};

   if (HAS_XLATE) begin : g_xl
      logic [5:0]        lg;
      logic [OFF_W-1:0]  idx_full;
      logic [IDX_W-1:0]  idx;
      logic [ADDR_W-1:0] mask;
      logic [ADDR_W-1:0] xl_addr;
      logic              win_ok;

      always_comb begin
         lg       = win_lg2(sz_code, MIN_LG, OFF_W);
         idx_full = off >> lg;
         idx      = idx_full[IDX_W-1:0];
         mask     = (ADDR_W'(1) << lg) - ADDR_W'(1);
         win_ok   = (idx_full < OFF_W'(NUM_WIN)) && win_vld[idx];
         xl_addr  = (win_base[idx] & ~mask) | (byp_addr & mask);
         ok       = in_ap && (!xl_en || win_ok);
         map_addr = xl_en ? xl_addr : byp_addr;
      end
   end else begin : g_byp
      wire unused_xl = ^{xl_en, sz_code, win_base, win_vld};
      assign ok       = in_ap;
      assign map_addr = byp_addr;
   end

endmodule

// File: rtl/pcie_obx_stage.sv
module pcie_obx_stage #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_ok,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   output logic              o_valid,
   input  logic              o_ready,
   output logic [ADDR_W-1:0] o_addr,
   output logic [DATA_W-1:0] o_data,
   output logic              o_err
);

   logic take;

   assign in_ready = !o_valid || o_ready;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_err   <= 1'b0;
         o_addr  <= '0;
         o_data  <= '0;
      end else begin
         o_err <= take && !in_ok;
         if (take) begin
            o_valid <= in_ok;
            if (in_ok) begin
               o_addr <= in_addr;
               o_data <= in_data;
            end
         end else if (o_ready) begin
            o_valid <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/pcie_obx_top.sv
module pcie_obx_top #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFF_W     = 28,
   parameter int unsigned MIN_LG    = 20,
   parameter int unsigned NUM_WIN   = 32,
   parameter int unsigned RST_SZ    = 3,
   parameter logic [31:0] APER_BASE = 32'h2000_0000,
   parameter bit          HAS_XLATE = 1'b1,
   localparam int unsigned CFG_AW   = $clog2(NUM_WIN) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [CFG_AW-1:0] cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              wr_valid,
   output logic              wr_ready,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              pcie_valid,
   input  logic              pcie_ready,
   output logic [ADDR_W-1:0] pcie_addr,
   output logic [DATA_W-1:0] pcie_data,
   output logic              range_err
);

   if (NUM_WIN < 2 || (NUM_WIN & (NUM_WIN - 1)) != 0) begin : g_bad_nwin
      $error("NUM_WIN must be a power of two, at least 2");
   end
   if (OFF_W < MIN_LG || OFF_W >= ADDR_W || ADDR_W > 32) begin : g_bad_off
      $error("need MIN_LG <= OFF_W < ADDR_W <= 32");
   end
   if (RST_SZ > 15) begin : g_bad_rst
      $error("RST_SZ must fit in four bits");
   end

   logic                           cfg_en;
   logic                           xl_en;
   logic [3:0]                     sz_code;
   logic [NUM_WIN-1:0][ADDR_W-1:0] win_base;
   logic [NUM_WIN-1:0]             win_vld;
   logic                           map_ok;
   logic [ADDR_W-1:0]              map_addr;

   pcie_obx_cfg #(
      .ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN), .RST_SZ(RST_SZ)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .xl_en(cfg_en), .sz_code(sz_code),
      .win_base(win_base), .win_vld(win_vld)
   );

   assign xl_en = cfg_en && HAS_XLATE;

   pcie_obx_map #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .MIN_LG(MIN_LG), .NUM_WIN(NUM_WIN),
      .APER_BASE(APER_BASE), .HAS_XLATE(HAS_XLATE)
   ) u_map (
      .addr(wr_addr), .xl_en(xl_en), .sz_code(sz_code),
      .win_base(win_base), .win_vld(win_vld),
      .ok(map_ok), .map_addr(map_addr)
   );

   pcie_obx_stage #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_stage (
      .clk(clk), .rst_n(rst_n), .in_valid(wr_valid), .in_ok(map_ok),
      .in_addr(map_addr), .in_data(wr_data), .in_ready(wr_ready),
      .o_valid(pcie_valid), .o_ready(pcie_ready), .o_addr(pcie_addr),
      .o_data(pcie_data), .o_err(range_err)
   );

endmodule

// File: rtl/pcie_obx_chk.sv
module pcie_obx_chk #(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned OFF_W     = 28,
   parameter logic [31:0] APER_BASE = 32'h2000_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xl_en,
   input logic              wr_valid,
   input logic              wr_ready,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              pcie_valid,
   input logic              pcie_ready,
   input logic [ADDR_W-1:0] pcie_addr,
   input logic [DATA_W-1:0] pcie_data,
   input logic              range_err
);

   logic acc;
   logic in_ap;
   assign acc   = wr_valid && wr_ready;
   assign in_ap = wr_addr[ADDR_W-1:OFF_W] == APER_BASE[ADDR_W-1:OFF_W];

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      pcie_valid && !pcie_ready |=> pcie_valid && $stable(pcie_addr) && $stable(pcie_data));

   a_r9_block: assert property (@(posedge clk) disable iff (!rst_n)
      pcie_valid && !pcie_ready |-> !wr_ready);

   a_r7_outside: assert property (@(posedge clk) disable iff (!rst_n)
      acc && !in_ap |=> range_err && !pcie_valid);

   a_r2_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_ap && !xl_en |=> pcie_valid &&
         pcie_addr == ADDR_W'($past(wr_addr[OFF_W-1:0])));

   a_r2_data: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> range_err || pcie_data == $past(wr_data));

   a_r6_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
      range_err |-> !pcie_valid && $past(acc));

   a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
      pcie_valid && pcie_ready |=> !pcie_valid || $past(acc));

endmodule

bind pcie_obx_top pcie_obx_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFF_W(OFF_W), .APER_BASE(APER_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .xl_en(xl_en), .wr_valid(wr_valid),
   .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
   .pcie_valid(pcie_valid), .pcie_ready(pcie_ready), .pcie_addr(pcie_addr),
   .pcie_data(pcie_data), .range_err(range_err)
);

// File: tb/pcie_obx_top_tb.sv
module pcie_obx_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        wr_valid = 1'b0;
   logic        wr_ready;
   logic [31:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        pcie_valid;
   logic        pcie_ready = 1'b1;
   logic [31:0] pcie_addr;
   logic [31:0] pcie_data;
   logic        range_err;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   pcie_obx_top dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
      .wr_addr(wr_addr), .wr_data(wr_data), .pcie_valid(pcie_valid),
      .pcie_ready(pcie_ready), .pcie_addr(pcie_addr), .pcie_data(pcie_data),
      .range_err(range_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // one write with pcie_ready high; checks forward/drop and the next cycle
   task automatic xfer(input string req, input logic [31:0] a, input logic [31:0] d,
                       input bit exp_ok, input logic [31:0] exp_a);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_valid = 1'b0;
      chk({req, " valid"}, 32'(pcie_valid), 32'(exp_ok));
      chk({req, " err"}, 32'(range_err), 32'(!exp_ok));
      if (exp_ok) begin
         chk({req, " addr"}, pcie_addr, exp_a);
         chk({req, " data"}, pcie_data, d);
      end
      @(negedge clk);
      chk({req, " R8 one cycle valid"}, 32'(pcie_valid), 32'd0);
      chk({req, " R6 one cycle err"}, 32'(range_err), 32'd0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 pcie_valid", 32'(pcie_valid), 32'd0);
      chk("R1 range_err", 32'(range_err), 32'd0);
      chk("R1 wr_ready", 32'(wr_ready), 32'd1);
   endtask

   task automatic t_bypass();
      xfer("R2 msi untranslated", 32'h2000_0010, 32'hCAFE_0001, 1'b1, 32'h0000_0010);
      xfer("R2 top of aperture", 32'h2FFF_FFFC, 32'h1234_5678, 1'b1, 32'h0FFF_FFFC);
      xfer("R7 outside bypass", 32'h3000_0010, 32'h1, 1'b0, 32'h0);
   endtask

   task automatic t_translate();
      cfg_wr(6'd32, 32'h6000_0001);
      cfg_wr(6'd33, 32'h9000_0001);
      cfg_wr(6'd0, 32'h0000_0031);
      xfer("R3 msi translated", 32'h2000_0010, 32'hBEEF_0002, 1'b1, 32'h6000_0010);
      xfer("R4 window one", 32'h2080_0010, 32'h5, 1'b1, 32'h9000_0010);
      xfer("R6 invalid window", 32'h2100_0004, 32'h6, 1'b0, 32'h0);
      xfer("R7 outside translated", 32'h1000_0000, 32'h7, 1'b0, 32'h0);
      cfg_wr(6'd33, 32'h9000_0000);
      xfer("R6 window cleared", 32'h2080_0010, 32'h8, 1'b0, 32'h0);
   endtask

   task automatic t_align();
      cfg_wr(6'd32, 32'h6012_3451);
      xfer("R5 base low bits", 32'h2000_0010, 32'h9, 1'b1, 32'h6000_0010);
   endtask

   task automatic t_clamp();
      xfer("R10 pre-clamp idx31 invalid", 32'h2FF0_0000, 32'hA, 1'b0, 32'h0);
      cfg_wr(6'd0, 32'h0000_00F1);
      xfer("R10 code15 single window", 32'h2FF0_0000, 32'hB, 1'b1, 32'h6FF0_0000);
   endtask

   task automatic t_small_win();
      cfg_wr(6'd63, 32'h7000_0001);
      cfg_wr(6'd0, 32'h0000_0001);
      xfer("R4 1MB window 31", 32'h21F0_0020, 32'hC, 1'b1, 32'h7000_0020);
      xfer("R6 index past count", 32'h2200_0000, 32'hD, 1'b0, 32'h0);
   endtask

   task automatic t_stall();
      cfg_wr(6'd0, 32'h0000_0030);
      @(negedge clk);
      pcie_ready = 1'b0;
      wr_valid = 1'b1; wr_addr = 32'h2000_0100; wr_data = 32'h1111_1111;
      @(negedge clk);
      wr_addr = 32'h2000_0200; wr_data = 32'h2222_2222;
      chk("R9 first held valid", 32'(pcie_valid), 32'd1);
      chk("R9 wr_ready low", 32'(wr_ready), 32'd0);
      repeat (3) @(negedge clk);
      chk("R9 addr stable", pcie_addr, 32'h0000_0100);
      chk("R9 data stable", pcie_data, 32'h1111_1111);
      chk("R9 still blocked", 32'(wr_ready), 32'd0);
      pcie_ready = 1'b1;
      @(negedge clk);
      wr_valid = 1'b0;
      chk("R9 second addr", pcie_addr, 32'h0000_0200);
      chk("R9 second data", pcie_data, 32'h2222_2222);
      chk("R9 second valid", 32'(pcie_valid), 32'd1);
      @(negedge clk);
      chk("R8 drained", 32'(pcie_valid), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_bypass();
      t_translate();
      t_align();
      t_clamp();
      t_small_win();
      t_stall();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule